// File: doc/BRIEF.md
# Latched Interrupt Source and Mask Unit

This unit takes six link-management event indications and records each one in a sticky flag. The flags form a source register, and reading that register clears them. A mask register selects which flags can drive a single registered interrupt line. The inputs can be pulses or held levels. Each one is edge-detected, so a condition that stays asserted raises its flag only once. Link loss is recognised on the falling edge of the link-status input.

Software reaches both registers through a small port: a select line, a read strobe, a write strobe, write data and read data. Read data is combinational and shows the selected register. A read strobe aimed at the source register clears every flag at the next clock edge. A flag whose event arrives in that same cycle stays set. The flags record events whether or not they are masked, so unmasking a pending flag raises the interrupt one cycle after the mask write. A parameter sets the active level of the interrupt line.

Top module: `irq_src_mask_unit`

## Requirements
- R1: After reset the source register reads 0, the mask register reads 0 and the interrupt output is inactive (low with the default active-high polarity).
- R2: A rising edge on an event input sets its source bit one clock later. The bit positions are: bit 1 page received, bit 2 parallel-detection fault, bit 3 partner acknowledge, bit 5 remote fault, bit 6 negotiation complete.
- R3: Source bit 4 sets when `link_up` falls from 1 to 0. A rising edge of `link_up` sets nothing.
- R4: An event input held high after its flag has been cleared does not set the flag again until the input goes low and rises again.
- R5: With `reg_sel`=0, `reg_rdata` shows the source flags. A cycle with `reg_rd`=1 and `reg_sel`=0 clears every flag at that clock edge. A read with `reg_sel`=1 clears nothing.
- R6: An event detected in the same cycle as a clearing read leaves its flag set after that edge.
- R7: With `reg_sel`=1, a cycle with `reg_wr`=1 loads `reg_wdata[7:0]` into the mask. The mask reads back in bits [7:0], and bits [15:8] read 0.
- R8: Source bit 0 and bits [15:8] always read 0.
- R9: Flags set whether or not their mask bit is 1.
- R10: The interrupt output, registered, equals the OR over bits 1..6 of (source AND mask) from the previous cycle. Unmasking a pending flag therefore asserts it one cycle after the mask write.
- R11: A write with `reg_sel`=0 changes neither the flags nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_page_rx | input | 1 | Page received indication |
| ev_pd_fault | input | 1 | Parallel-detection fault indication |
| ev_lp_ack | input | 1 | Link-partner acknowledge indication |
| link_up | input | 1 | Link status level |
| ev_rem_fault | input | 1 | Remote fault indication |
| ev_an_done | input | 1 | Auto-negotiation complete indication |
| reg_sel | input | 1 | 0 = source register, 1 = mask register |
| reg_rd | input | 1 | Read strobe; clears the flags when `reg_sel`=0 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench drives held levels across a clearing read. A design that re-triggers on level would raise the flag again in the next cycle. It places an event on the same edge as a clearing read, where a design that clears first would lose that event. It toggles `link_up` in both directions, which catches a design that reacts to link-up or misses link loss. It also unmasks a flag that latched while masked: a design that gates capture with the mask would never raise the interrupt, and an unregistered path would raise it a cycle early. Writes to the source register and reads of the mask register check that neither clears or alters state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned MASK_W  = 8;
  // index of each event inside the internal flag vector (source bit = index + 1)
  localparam int unsigned IDX_PAGE  = 0;
  localparam int unsigned IDX_PDF   = 1;
  localparam int unsigned IDX_ACK   = 2;
  localparam int unsigned IDX_LDOWN = 3;
  localparam int unsigned IDX_RFLT  = 4;
  localparam int unsigned IDX_DONE  = 5;
  typedef enum logic {SEL_SOURCE = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int unsigned N = 6,
  parameter logic [N-1:0] FALL_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    if (FALL_SEL[i]) begin : g_fall
      assign ev_o[i] = prev_q[i] & ~lvl_i[i];
      assert_fall_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[i] |-> !lvl_i[i]);
    end else begin : g_rise
      assign ev_o[i] = lvl_i[i] & ~prev_q[i];
      assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[i] |-> lvl_i[i]);
      assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i[i] && ev_o[i]) |=> !ev_o[i]);
    end
  end
endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = clr_i ? '0 : flags_q;
    flags_d = flags_d | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> flags_o[i]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && !clr_i) |=> flags_o[i]);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !ev_i[i]) |=> !flags_o[i]);
    assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && ev_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/irq_src_mask_unit.sv
module irq_src_mask_unit
  import irq_pkg::*;
#(
  parameter bit IRQ_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_page_rx,
  input  logic              ev_pd_fault,
  input  logic              ev_lp_ack,
  input  logic              link_up,
  input  logic              ev_rem_fault,
  input  logic              ev_an_done,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  localparam logic [NUM_SRC-1:0] FALL_SEL = NUM_SRC'(1) << IDX_LDOWN;
  localparam logic IRQ_IDLE = ~IRQ_ACTIVE_HIGH;

  logic               rst_ns;
  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] ev;
  logic [NUM_SRC-1:0] flags;
  logic               clr_en;
  logic               mask_en;
  logic [MASK_W-1:0]  mask_q;
  logic [MASK_W-1:0]  mask_d;
  logic               hit;
  logic               irq_q;
  logic               irq_d;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  always_comb begin
    lvl            = '0;
    lvl[IDX_PAGE]  = ev_page_rx;
    lvl[IDX_PDF]   = ev_pd_fault;
    lvl[IDX_ACK]   = ev_lp_ack;
    lvl[IDX_LDOWN] = link_up;
    lvl[IDX_RFLT]  = ev_rem_fault;
    lvl[IDX_DONE]  = ev_an_done;
  end

  irq_edge_bank #(.N(NUM_SRC), .FALL_SEL(FALL_SEL)) u_edge (
    .clk(clk), .rst_n(rst_ns), .lvl_i(lvl), .ev_o(ev));

  assign clr_en  = reg_rd & (reg_sel == SEL_SOURCE);
  assign mask_en = reg_wr & (reg_sel == SEL_MASK);

  irq_flag_latch #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_ns), .ev_i(ev), .clr_i(clr_en), .flags_o(flags));

  // mask register with explicit load enable
  always_comb mask_d = mask_en ? reg_wdata[MASK_W-1:0] : mask_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  // source bit k+1 is gated by mask bit k+1
  assign hit   = |(flags & mask_q[NUM_SRC:1]);
  assign irq_d = hit ? IRQ_ACTIVE_HIGH : IRQ_IDLE;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq_q <= IRQ_IDLE;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_MASK) reg_rdata[MASK_W-1:0] = mask_q;
    else                     reg_rdata[NUM_SRC:1]  = flags;
  end

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    hit |=> (irq_o == IRQ_ACTIVE_HIGH));
  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    !hit |=> (irq_o == IRQ_IDLE));
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_sel == SEL_SOURCE) |-> (reg_rdata[REG_W-1:MASK_W] == '0 && !reg_rdata[0]));
  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !mask_en |=> $stable(mask_q));
  assert_mask_upper_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_sel == SEL_MASK) |-> (reg_rdata[REG_W-1:MASK_W] == '0));
endmodule

// File: tb/irq_src_mask_unit_tb.sv
module irq_src_mask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_page_rx, ev_pd_fault, ev_lp_ack, link_up, ev_rem_fault, ev_an_done;
  logic        reg_sel, reg_rd, reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  // bench model (source bits 6..1 stored as m_flags[5:0])
  logic [5:0] m_flags, m_prev;
  logic [7:0] m_mask;
  logic       m_irq;
  string      tag;

  always #2.5 clk = ~clk;

  irq_src_mask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ev_page_rx(ev_page_rx), .ev_pd_fault(ev_pd_fault),
    .ev_lp_ack(ev_lp_ack), .link_up(link_up), .ev_rem_fault(ev_rem_fault),
    .ev_an_done(ev_an_done), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  function automatic logic [5:0] in_vec();
    return {ev_an_done, ev_rem_fault, link_up, ev_lp_ack, ev_pd_fault, ev_page_rx};
  endfunction

  function automatic logic [5:0] model_ev(logic [5:0] cur, logic [5:0] prv);
    logic [5:0] e;
    e    = cur & ~prv;
    e[3] = prv[3] & ~cur[3];   // link loss (R3)
    return e;
  endfunction

  function automatic logic [15:0] model_rdata(logic s);
    return s ? {8'h00, m_mask} : {8'h00, 1'b0, m_flags, 1'b0};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: check at negedge, drive, advance model at posedge
  task automatic step(input logic [5:0] lv, input logic s, input logic rd,
                      input logic wr, input logic [15:0] wd);
    logic [5:0] nf;
    logic [7:0] nm;
    logic       ni;
    @(negedge clk);
    check(reg_rdata, model_rdata(reg_sel), "rdata");
    check({15'd0, irq_o}, {15'd0, m_irq}, "irq");
    {ev_an_done, ev_rem_fault, link_up, ev_lp_ack, ev_pd_fault, ev_page_rx} = lv;
    reg_sel = s; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    nf = ((rd && !s) ? 6'd0 : m_flags) | model_ev(lv, m_prev);
    nm = (wr && s) ? wd[7:0] : m_mask;
    ni = |(m_flags & m_mask[6:1]);
    @(posedge clk);
    m_flags = nf; m_mask = nm; m_irq = ni; m_prev = lv;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] lv;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0;
    {ev_an_done, ev_rem_fault, link_up, ev_lp_ack, ev_pd_fault, ev_page_rx} = '0;
    reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    m_flags = '0; m_prev = '0; m_mask = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    tag = "R1";
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'd0, 1'b1, 1'b0, 1'b0, 16'h0);
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R2";   // each rising input, masked off (also R9)
    for (int i = 0; i < 6; i++) begin
      if (i != 3) begin
        step(6'(1 << i), 1'b0, 1'b0, 1'b0, 16'h0);
        step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      end
    end
    tag = "R9";
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R5";   // mask read leaves flags, source read clears
    step(6'd0, 1'b1, 1'b1, 1'b0, 16'h0);
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'd0, 1'b0, 1'b1, 1'b0, 16'h0);
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R3";   // link up sets nothing, link down sets bit 4
    step(6'b001000, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'b001000, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'b000000, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'b000000, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R4";   // held level across a clear
    step(6'b000001, 1'b0, 1'b1, 1'b0, 16'h0);
    step(6'b000001, 1'b0, 1'b1, 1'b0, 16'h0);
    step(6'b000001, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'b000001, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R6";   // event on the clearing edge
    step(6'b100001, 1'b0, 1'b1, 1'b0, 16'h0);
    step(6'b100001, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R11";  // write aimed at source
    step(6'b100001, 1'b0, 1'b0, 1'b1, 16'hFFFF);
    step(6'b100001, 1'b1, 1'b0, 1'b0, 16'h0);
    step(6'b100001, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R10";  // unmask pending bit 6
    step(6'b100001, 1'b1, 1'b0, 1'b1, 16'h0040);
    step(6'b100001, 1'b1, 1'b0, 1'b0, 16'h0);
    step(6'b100001, 1'b1, 1'b0, 1'b0, 16'h0);
    step(6'b000000, 1'b0, 1'b1, 1'b0, 16'h0);
    step(6'b000000, 1'b0, 1'b0, 1'b0, 16'h0);
    step(6'b000000, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R7";
    step(6'd0, 1'b1, 1'b0, 1'b1, 16'hA5FF);
    step(6'd0, 1'b1, 1'b0, 1'b0, 16'h0);
    step(6'd0, 1'b1, 1'b0, 1'b1, 16'h0000);
    step(6'd0, 1'b0, 1'b0, 1'b0, 16'h0);

    tag = "R8";   // random mix; reserved bits checked on every source read
    lv = '0;
    for (int k = 0; k < 3000; k++) begin
      logic s, rd, wr;
      for (int b = 0; b < 6; b++)
        if ($urandom_range(7) == 0) lv[b] = ~lv[b];
      s  = 1'($urandom_range(1));
      rd = ($urandom_range(5) == 0);
      wr = ($urandom_range(9) == 0);
      step(lv, s, rd, wr, 16'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule